// File: doc/BRIEF.md
# Keyed-Write Watchdog and Interval Timer

This block is an 8-bit up-counting timer on a small 16-bit register bus. It runs either as a watchdog or as an interval timer. A free-running prescaler divides the system clock by one of eight ratios, and each prescaler tick advances the counter. In interval mode, a wrap from 0xFF to 0x00 sets a flag in the control register and sends a one-cycle interrupt pulse. In watchdog mode, the same wrap sets a sticky overflow flag in the reset control register. It also clears the counter and control register, which stops the timer. If reset generation is enabled, it raises a 128-cycle reset request of a chosen type.

The counter and the control register share one write address, so a stray store cannot easily change them. A word write only takes effect when its upper byte carries the right key, and byte writes to that address do nothing. The overflow flag can only be cleared in two steps: software reads it as 1, then writes 0 to it.

A small state machine generates the reset request. It has three states: `RG_IDLE`, `RG_PWR` (power-on request active) and `RG_MAN` (manual request active). The transition `RG_IDLE -> RG_PWR` fires on a watchdog overflow when reset generation is enabled and the type bit is 0. The transition `RG_IDLE -> RG_MAN` fires on the same event when the type bit is 1. The transitions `RG_PWR -> RG_IDLE` and `RG_MAN -> RG_IDLE` fire when the pulse counter reaches its last cycle. A watchdog overflow while a request is already active is ignored.

Top module: `keyed_wdt`

## Requirements
- R1: A word write to address 0 with upper byte 0x5A loads the lower byte into the counter. Reading address 0 returns the counter in bits 7:0.
- R2: A word write to address 0 with upper byte 0xA5 loads the control register. Reading address 1 returns the control register. Its bit layout is:
  - bit 7: interval flag
  - bit 6: mode (1 = watchdog, 0 = interval)
  - bit 5: run enable
  - bits 4:3: always read 0
  - bits 2:0: tap select
- R3: Byte writes to address 0, and word writes to address 0 with any upper byte other than 0x5A or 0xA5, change neither the counter nor the control register.
- R4: While the run bit is 1, the counter advances by one every D clocks. D is 2, 4, 8, 16, 32, 64, 512 or 4096 for tap values 0 to 7. With the run bit at 0, the counter holds.
- R5: A watchdog-mode overflow (0xFF to 0x00) has three effects:
  - it sets bit 7 of the reset control register (address 2);
  - it leaves the counter at 0;
  - it clears the control register to 0.
- R6: An interval-mode overflow has these effects:
  - it sets control bit 7;
  - it pulses `irq_o` for exactly one cycle;
  - it lets the counter wrap to 0 and keep running;
  - it leaves reset control bit 7 and both reset requests untouched.

  Writing control bit 7 as 0 clears the interval flag.
- R7: Reset control bit 7 clears only on a write with bit 7 = 0 that follows a read of address 2 which returned bit 7 = 1. Writing 1 never sets it. Any write to address 2 uses up a prior read.
- R8: With reset control bit 6 at 1, a watchdog overflow raises a reset request for exactly 128 clocks. With bit 6 at 0, no request is raised.
- R9: Reset control bit 5 picks which request is raised: 0 drives `por_req_o`, 1 drives `man_req_o`.
- R10: Reset control bits 4:0 always read as 1. After reset, the reset control register reads 0x1F, and the counter, control register and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (arms the overflow-flag clear) |
| wr_word | input | 1 | 1 = 16-bit write, 0 = byte write |
| addr | input | 2 | Register address: 0 keyed counter/control, 1 control read, 2 reset control |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| irq_o | output | 1 | One-cycle interval interrupt pulse |
| por_req_o | output | 1 | Power-on-type reset request |
| man_req_o | output | 1 | Manual-type reset request |

## Verification
The bench checks the keyed address with a wrong key and with a byte write. A design that decoded only the address would corrupt the counter there. It checks the two-step flag clear by writing 0 without a prior read. A design that skipped the arming step would drop the flag at that point. It measures the reset request length and the prescaler ratios edge by edge, including the slowest tap. A design that is one cycle off in either would show up in those counts. In interval mode, the bench confirms that the watchdog flag and the reset outputs stay quiet while the interrupt pulses once.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;

    typedef enum logic [1:0] {
        RG_IDLE,
        RG_PWR,
        RG_MAN
    } rg_state_t;

    typedef struct packed {
        logic       iflag;
        logic       wd_mode;
        logic       run;
        logic [1:0] pad;
        logic [2:0] tap;
    } ctl_t;

    localparam logic [1:0] A_KEYED = 2'd0;
    localparam logic [1:0] A_CTL   = 2'd1;
    localparam logic [1:0] A_RST   = 2'd2;

    // prescaler exponent per tap: divide ratio is 2**shift
    function automatic int unsigned tap_shift(input logic [2:0] tap);
        case (tap)
            3'd6:    return 9;
            3'd7:    return 12;
            default: return 32'(tap) + 1;
        endcase
    endfunction

endpackage

// File: rtl/keyed_wdt_prescale.sv
module keyed_wdt_prescale
    import keyed_wdt_pkg::*;
#(
    parameter int PRE_W = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic [2:0] tap_i,
    output logic       tick_o
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask   = PRE_W'((32'd1 << tap_shift(tap_i)) - 32'd1);
        tick_o = run_i && ((pre_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pre_q <= '0;
        else if (!run_i) pre_q <= '0;
        else             pre_q <= pre_q + 1'b1;
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R4

endmodule

// File: rtl/keyed_wdt_rstgen.sv
module keyed_wdt_rstgen
    import keyed_wdt_pkg::*;
#(
    parameter int PULSE_LEN = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic manual_i,
    output logic por_o,
    output logic man_o
);

    localparam int CW = $clog2(PULSE_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(PULSE_LEN - 1);

    rg_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RG_IDLE: if (start_i) state_d = manual_i ? RG_MAN : RG_PWR;
            RG_PWR,
            RG_MAN:  if (cnt_q == LAST) state_d = RG_IDLE;
            default: state_d = RG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RG_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == RG_IDLE) ? '0 : cnt_q + 1'b1;
        end
    end

    always_comb begin
        por_o = (state_q == RG_PWR);
        man_o = (state_q == RG_MAN);
    end

    AST_PULSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != RG_IDLE && cnt_q != LAST) |=> state_q == $past(state_q)); // R8

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import keyed_wdt_pkg::*;
#(
    parameter logic [7:0] KEY_CNT   = 8'h5A,
    parameter logic [7:0] KEY_CTL   = 8'hA5,
    parameter int         PRE_W     = 12,
    parameter int         PULSE_LEN = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic        wr_word,
    input  logic [1:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        irq_o,
    output logic        por_req_o,
    output logic        man_req_o
);

    logic [7:0] cnt_q;
    ctl_t       ctl_q;
    logic       wovf_q, rste_q, rsts_q, arm_q, irq_q;
    logic       tick, ovf, wd_ovf, iv_ovf;
    logic       wr_cnt, wr_ctl, wr_rst, rd_hit;
    logic       unused_bits;

    assign unused_bits = ^wdata[4:3];

    always_comb begin
        wr_cnt = wr_en && wr_word && addr == A_KEYED && wdata[15:8] == KEY_CNT;
        wr_ctl = wr_en && wr_word && addr == A_KEYED && wdata[15:8] == KEY_CTL;
        wr_rst = wr_en && addr == A_RST;
        rd_hit = rd_en && addr == A_RST && wovf_q;
        ovf    = tick && cnt_q == 8'hFF;
        wd_ovf = ovf && ctl_q.wd_mode;
        iv_ovf = ovf && !ctl_q.wd_mode;
    end

    keyed_wdt_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (ctl_q.run),
        .tap_i  (ctl_q.tap),
        .tick_o (tick)
    );

    keyed_wdt_rstgen #(.PULSE_LEN(PULSE_LEN)) u_rg (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (wd_ovf && rste_q),
        .manual_i (rsts_q),
        .por_o    (por_req_o),
        .man_o    (man_req_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            ctl_q  <= '0;
            wovf_q <= 1'b0;
            rste_q <= 1'b0;
            rsts_q <= 1'b0;
            arm_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (wr_cnt)      cnt_q <= wdata[7:0];
            else if (wd_ovf) cnt_q <= '0;
            else if (tick)   cnt_q <= cnt_q + 1'b1;

            if (wd_ovf) begin
                ctl_q <= '0;
            end else begin
                if (wr_ctl) begin
                    ctl_q.wd_mode <= wdata[6];
                    ctl_q.run     <= wdata[5];
                    ctl_q.tap     <= wdata[2:0];
                    ctl_q.iflag   <= ctl_q.iflag & wdata[7];
                end
                if (iv_ovf) ctl_q.iflag <= 1'b1;
            end

            if (wd_ovf)                          wovf_q <= 1'b1;
            else if (wr_rst && !wdata[7] && arm_q) wovf_q <= 1'b0;

            if (wr_rst) begin
                rste_q <= wdata[6];
                rsts_q <= wdata[5];
                arm_q  <= 1'b0;
            end else if (rd_hit) begin
                arm_q  <= 1'b1;
            end

            irq_q <= iv_ovf;
        end
    end

    assign irq_o = irq_q;

    always_comb begin
        case (addr)
            A_KEYED: rdata = {8'h00, cnt_q};
            A_CTL:   rdata = {8'h00, ctl_q};
            A_RST:   rdata = {8'h00, wovf_q, rste_q, rsts_q, 5'h1F};
            default: rdata = 16'h0000;
        endcase
    end

    AST_KEY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cnt && !tick) |=> cnt_q == $past(cnt_q)); // R3
    AST_FLAG_CLEAR_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wovf_q) |-> $past(arm_q)); // R7
    AST_FLAG_WD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wovf_q) |-> $past(ctl_q.wd_mode)); // R6
    AST_REQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(por_req_o) || $rose(man_req_o)) |-> wovf_q); // R8
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R6

endmodule

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, wr_word = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'h0000;
    logic [15:0] rdata;
    logic        irq, por_req, man_req;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    keyed_wdt u_keyed_wdt (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .wr_word(wr_word), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_o(irq), .por_req_o(por_req), .man_req_o(man_req)
    );

    task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [15:0] d, input logic w);
        wr_en = 1'b1; wr_word = w; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; wr_word = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [15:0] v);
        rd_en = 1'b1; addr = a; #1 v = rdata;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [15:0] v);
        addr = a; #1 v = rdata;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        peek(0, v); chk("R10 counter after reset", v, 16'h0000);
        peek(1, v); chk("R10 control after reset", v, 16'h0000);
        peek(2, v); chk("R10 reset ctl after reset", v, 16'h001F);
        chk("R10 outputs after reset", {13'd0, irq, por_req, man_req}, 16'h0000);
    endtask

    task automatic t_rcsr_rw();
        logic [15:0] v;
        bus_wr(2, 16'h00FF, 1'b1);
        peek(2, v); chk("R7 R10 writing ones", v, 16'h007F);
        bus_wr(2, 16'h0000, 1'b1);
        peek(2, v); chk("R10 reserved stay one", v, 16'h001F);
    endtask

    task automatic t_keys();
        logic [15:0] v;
        bus_wr(0, 16'h5A33, 1'b1);
        peek(0, v); chk("R1 keyed counter load", v, 16'h0033);
        bus_wr(0, 16'h5B44, 1'b1);
        peek(0, v); chk("R3 wrong key counter", v, 16'h0033);
        bus_wr(0, 16'h5A44, 1'b0);
        peek(0, v); chk("R3 byte write counter", v, 16'h0033);
        bus_wr(0, 16'hA51F, 1'b0);
        peek(1, v); chk("R3 byte write control", v, 16'h0000);
        bus_wr(0, 16'hA503, 1'b1);
        peek(1, v); chk("R2 keyed control load", v, 16'h0003);
        peek(0, v); chk("R2 control key spares counter", v, 16'h0033);
    endtask

    task automatic t_prescale();
        logic [15:0] v;
        bus_wr(0, 16'hA500, 1'b1);
        bus_wr(0, 16'h5A00, 1'b1);
        repeat (20) @(posedge clk);
        @(negedge clk);
        peek(0, v); chk("R4 halted counter holds", v, 16'h0000);
        bus_wr(0, 16'hA522, 1'b1);
        repeat (80) @(posedge clk);
        @(negedge clk);
        peek(0, v); chk("R4 divide 8 after 80", v, 16'h000A);
        repeat (7) @(posedge clk);
        @(negedge clk);
        peek(0, v); chk("R4 divide 8 after 87", v, 16'h000A);
        @(posedge clk); @(negedge clk);
        peek(0, v); chk("R4 divide 8 after 88", v, 16'h000B);
        bus_wr(0, 16'hA500, 1'b1);
        bus_wr(0, 16'h5A00, 1'b1);
        bus_wr(0, 16'hA527, 1'b1);
        repeat (4095) @(posedge clk);
        @(negedge clk);
        peek(0, v); chk("R4 divide 4096 before", v, 16'h0000);
        @(posedge clk); @(negedge clk);
        peek(0, v); chk("R4 divide 4096 edge", v, 16'h0001);
        bus_wr(0, 16'hA500, 1'b1);
    endtask

    task automatic t_interval();
        logic [15:0] v;
        bus_wr(0, 16'h5AFF, 1'b1);
        bus_wr(0, 16'hA520, 1'b1);
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R6 irq on overflow", {15'd0, irq}, 16'h0001);
        peek(0, v); chk("R6 counter wraps", v, 16'h0000);
        peek(1, v); chk("R6 interval flag set", v, 16'h00A0);
        peek(2, v); chk("R6 watchdog flag untouched", v, 16'h001F);
        chk("R6 no reset request", {14'd0, por_req, man_req}, 16'h0000);
        @(posedge clk); @(negedge clk);
        chk("R6 irq single cycle", {15'd0, irq}, 16'h0000);
        bus_wr(0, 16'hA520, 1'b1);
        peek(1, v); chk("R6 interval flag cleared", v, 16'h0020);
        bus_wr(0, 16'hA500, 1'b1);
    endtask

    task automatic t_wd(input logic rste, input logic rsts);
        logic [15:0] v;
        int n;
        bus_rd(2, v);
        bus_wr(2, {8'h00, 1'b0, rste, rsts, 5'h00}, 1'b1);
        bus_wr(0, 16'h5AFE, 1'b1);
        bus_wr(0, 16'hA560, 1'b1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        peek(0, v); chk("R5 count before overflow", v, 16'h00FF);
        chk("R8 no request early", {14'd0, por_req, man_req}, 16'h0000);
        @(posedge clk); @(negedge clk);
        peek(0, v); chk("R5 counter at zero", v, 16'h0000);
        peek(1, v); chk("R5 control cleared", v, 16'h0000);
        peek(2, v); chk("R5 overflow flag set", v, {8'h00, 1'b1, rste, rsts, 5'h1F});
        chk("R9 power-on request", {15'd0, por_req}, {15'd0, rste && !rsts});
        chk("R9 manual request", {15'd0, man_req}, {15'd0, rste && rsts});
        if (rste) begin
            n = 1;
            for (int i = 0; i < 400; i++) begin
                @(posedge clk); @(negedge clk);
                if (por_req || man_req) n++;
                else break;
            end
            chk("R8 request length", 16'(n), 16'd128);
        end else begin
            n = 0;
            for (int i = 0; i < 10; i++) begin
                @(posedge clk); @(negedge clk);
                if (por_req || man_req) n++;
            end
            chk("R8 disabled gives no request", 16'(n), 16'd0);
        end
    endtask

    task automatic t_flag_clear();
        logic [15:0] v;
        bus_wr(2, 16'h0000, 1'b1);
        peek(2, v); chk("R7 write zero without read", v, 16'h009F);
        bus_rd(2, v); chk("R7 read sees flag", v, 16'h009F);
        bus_wr(2, 16'h0080, 1'b1);
        peek(2, v); chk("R7 write one keeps flag", v, 16'h009F);
        bus_rd(2, v);
        bus_wr(2, 16'h0000, 1'b1);
        peek(2, v); chk("R7 read then write zero clears", v, 16'h001F);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rcsr_rw();
        t_keys();
        t_prescale();
        t_interval();
        t_wd(1'b1, 1'b0);
        t_wd(1'b1, 1'b1);
        t_wd(1'b0, 1'b1);
        t_flag_clear();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule